// File: doc/BRIEF.md
# HDLC Serial Transmit Framer

This block turns bytes into a bit-synchronous HDLC frame on a serial line. The line clock drives it, and it puts out one line bit per clock. Software first fills a small byte buffer. It then raises a one-cycle enable. The framer sends these parts in order:

- an opening flag;
- every buffered byte, in write order;
- a frame check sequence computed in hardware;
- a closing flag.

Zero-bit insertion keeps the payload and check sequence from imitating a flag. Between frames the line rests at logic one. After each closing flag it holds a programmable number of idle ones before it reports completion.

While a frame is in flight, the framer ignores writes to the buffer and ignores further enable pulses. The frame is therefore exactly the buffer contents at the moment of enable, and payloads are always whole bytes. An abort request cuts the frame short: the framer sends a run of ones, discards the bytes it has not sent, and raises an abort status. A top-level parameter picks the check sequence: a 16-bit CRC or a 32-bit CRC. Software may read the status outputs or ignore them.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset the line output is 1, and busy, done, aborted and the buffer level are all 0.
- R2: A write while not busy and while the level is below DEPTH stores the byte and raises the level by one. A write with the level at DEPTH is dropped and the level stays at DEPTH.
- R3: An enable pulse with a non-empty buffer and no frame in flight starts a frame. The frame is the flag 0x7E sent LSB first (bit sequence 0,1,1,1,1,1,1,0), then each buffered byte LSB first in write order, then the check sequence, then the same flag again.
- R4: Inside the bytes and the check sequence, a 0 is inserted after every five consecutive 1s. This includes a run that ends on the last check bit, so the 0 comes before the closing flag. Flags, abort runs and idle ones are never stuffed.
- R5: The check sequence is computed over the payload bits, LSB first, with a right-shifting CRC whose register starts at all ones. With FCS32=0 the feedback mask is 0x8408 and the register is 16 bits. With FCS32=1 the mask is 0xEDB88320 and the register is 32 bits. The final register is complemented and sent LSB first.
- R6: While busy, writes and enable pulses have no effect, and the frame carries only the bytes present at enable. An enable with an empty buffer starts nothing. Once a frame ends the buffer is empty.
- R7: After the last closing-flag bit, the line carries exactly idle_len ones. Done rises and busy falls in the cycle that carries the last of those ones (in the cycle of the last flag bit when idle_len is 0). The line then stays at 1 until the next frame.
- R8: An abort request while the frame body or flags are being sent does the following: the line carries ABORT_LEN (default 8) consecutive ones starting with the next bit, the unsent bytes are discarded so the level is 0, aborted goes to 1, and the idle gap and done follow as in R7.
- R9: An accepted enable clears done and aborted and raises busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe into the buffer |
| wr_data | input | 8 | Byte to store |
| tx_enable | input | 1 | One-cycle pulse that starts a frame |
| abort_req | input | 1 | One-cycle pulse that aborts the frame in flight |
| idle_len | input | IDLE_W | Number of idle ones after each frame |
| txd | output | 1 | Serial line bit |
| tx_busy | output | 1 | Frame or its idle gap in progress |
| tx_done | output | 1 | Last frame finished; cleared by the next accepted enable |
| tx_aborted | output | 1 | Last frame was aborted; cleared by the next accepted enable |
| buf_level | output | $clog2(DEPTH)+1 | Bytes held in the buffer |

## Verification
The bench uses two instances, one per check-sequence width, and compares both line streams bit for bit against a model. The model stuffs zeros and computes the CRC from the rules above. The stimulus contains 0xFF-heavy payloads, so the five-ones rule fires often and sometimes right at the byte or check-sequence edge. A design that forgets to stuff there, or that stuffs inside a flag, shifts every later bit and fails the comparison.

Done is timed against the idle gap for gaps of zero and non-zero length, which catches an off-by-one count. The bench also writes and pulses enable in mid-frame, overfills the buffer, and enables with an empty buffer. A design that leaks those actions would show extra bytes on the line or a wrong level. An abort on an all-zero payload must give exactly ABORT_LEN ones and an emptied buffer.

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int DEPTH     = 16,
  parameter bit FCS32     = 1'b0,
  parameter int ABORT_LEN = 8,
  parameter int IDLE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              tx_enable,
  input  logic              abort_req,
  input  logic [IDLE_W-1:0] idle_len,
  output logic              txd,
  output logic              tx_busy,
  output logic              tx_done,
  output logic              tx_aborted,
  output logic [$clog2(DEPTH):0] buf_level
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = FCS32 ? 32 : 16;
  localparam logic [FW-1:0] POLY = FCS32 ? FW'(32'hEDB88320) : FW'(32'h00008408);
  localparam logic [FW-1:0] FLAG = FW'(8'h7E);

  typedef enum logic [2:0] {S_IDLE, S_OPEN, S_DATA, S_FCS, S_CLOSE, S_ABORT, S_GAP} st_t;

  st_t               st;
  logic [7:0]        mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [AW:0]       cnt;
  logic [FW-1:0]     sh, crc;
  logic [4:0]        bitn;
  logic [2:0]        ones;
  logic [IDLE_W-1:0] gcnt;
  logic              busy, done, abrt, line;

  wire full   = cnt == (AW+1)'(DEPTH);
  wire empty  = cnt == '0;
  wire push   = wr_en && !busy && !full;
  wire start  = tx_enable && !busy && !empty;
  wire kill   = abort_req && busy && st != S_ABORT && st != S_GAP;
  wire stuff  = (st == S_DATA || st == S_FCS || st == S_CLOSE) && ones == 3'd5;
  wire last   = bitn == 5'd0;
  wire fb     = crc[0] ^ sh[0];
  wire [FW-1:0] crc_nx = (crc >> 1) ^ (fb ? POLY : '0);
  wire pop    = !kill && !stuff && last &&
                (st == S_OPEN || (st == S_DATA && !empty));

  assign txd        = line;
  assign tx_busy    = busy;
  assign tx_done    = done;
  assign tx_aborted = abrt;
  assign buf_level  = cnt;

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (kill) begin
      rp  <= wp;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      line <= 1'b1;
      sh   <= '0;
      crc  <= '1;
      bitn <= '0;
      ones <= '0;
      gcnt <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      abrt <= 1'b0;
    end else if (kill) begin
      st   <= S_ABORT;
      line <= 1'b1;
      ones <= '0;
      abrt <= 1'b1;
      gcnt <= IDLE_W'(ABORT_LEN-2);
    end else begin
      case (st)
        S_IDLE: begin
          line <= 1'b1;
          if (start) begin
            st   <= S_OPEN;
            sh   <= FLAG;
            bitn <= 5'd7;
            busy <= 1'b1;
            done <= 1'b0;
            abrt <= 1'b0;
            crc  <= '1;
            ones <= '0;
          end
        end
        S_OPEN: begin
          line <= sh[0];
          sh   <= sh >> 1;
          bitn <= bitn - 5'd1;
          if (last) begin
            st   <= S_DATA;
            sh   <= FW'(mem[rp]);
            bitn <= 5'd7;
          end
        end
        S_DATA, S_FCS: begin
          if (stuff) begin
            line <= 1'b0;
            ones <= '0;
          end else begin
            line <= sh[0];
            sh   <= sh >> 1;
            bitn <= bitn - 5'd1;
            ones <= sh[0] ? ones + 3'd1 : 3'd0;
            if (st == S_DATA) crc <= crc_nx;
            if (last) begin
              if (st == S_DATA && !empty) begin
                sh   <= FW'(mem[rp]);
                bitn <= 5'd7;
              end else if (st == S_DATA) begin
                st   <= S_FCS;
                sh   <= ~crc_nx;
                bitn <= 5'(FW-1);
              end else begin
                st   <= S_CLOSE;
                sh   <= FLAG;
                bitn <= 5'd7;
              end
            end
          end
        end
        S_CLOSE: begin
          if (stuff) begin
            line <= 1'b0;
            ones <= '0;
          end else begin
            line <= sh[0];
            sh   <= sh >> 1;
            bitn <= bitn - 5'd1;
            ones <= '0;
            if (last) begin
              if (idle_len == '0) begin
                st   <= S_IDLE;
                busy <= 1'b0;
                done <= 1'b1;
              end else begin
                st   <= S_GAP;
                gcnt <= idle_len;
              end
            end
          end
        end
        S_ABORT: begin
          line <= 1'b1;
          gcnt <= gcnt - IDLE_W'(1);
          if (gcnt == '0) begin
            if (idle_len == '0) begin
              st   <= S_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              st   <= S_GAP;
              gcnt <= idle_len;
            end
          end
        end
        S_GAP: begin
          line <= 1'b1;
          gcnt <= gcnt - IDLE_W'(1);
          if (gcnt == IDLE_W'(1)) begin
            st   <= S_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk #(
  parameter int DEPTH = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  tx_enable,
  input logic                  abort_req,
  input logic                  txd,
  input logic                  tx_busy,
  input logic                  tx_done,
  input logic                  tx_aborted,
  input logic [$clog2(DEPTH):0] buf_level
);
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    buf_level <= ($clog2(DEPTH)+1)'(DEPTH));

  a_r6_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy && wr_en |=> buf_level <= $past(buf_level));

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_busy && tx_done));

  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy && $past(!tx_busy) |-> txd);

  a_r8_abort_line: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy && abort_req |=> txd && buf_level == '0);

  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !tx_done && !tx_aborted);

  a_r6_enable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_enable && !tx_busy && buf_level == '0 |=> !tx_busy);
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tx_enable(tx_enable),
  .abort_req(abort_req), .txd(txd), .tx_busy(tx_busy), .tx_done(tx_done),
  .tx_aborted(tx_aborted), .buf_level(buf_level)
);

// File: tb/sim_hdlc_tx_framer.sv
module sim_hdlc_tx_framer;
  localparam int DEPTH = 16;
  localparam int IW    = 8;
  localparam int LOGN  = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, tx_enable = 1'b0, abort_req = 1'b0;
  logic [7:0] wr_data = '0;
  logic [IW-1:0] idle_len = '0;
  logic txd0, busy0, done0, ab0, txd1, busy1, done1, ab1;
  logic [$clog2(DEPTH):0] lvl0, lvl1;

  always #4 clk = ~clk;

  hdlc_tx_framer #(.DEPTH(DEPTH), .FCS32(1'b0), .IDLE_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tx_enable(tx_enable),
    .abort_req(abort_req), .idle_len(idle_len), .txd(txd0), .tx_busy(busy0),
    .tx_done(done0), .tx_aborted(ab0), .buf_level(lvl0));

  hdlc_tx_framer #(.DEPTH(DEPTH), .FCS32(1'b1), .IDLE_W(IW)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tx_enable(tx_enable),
    .abort_req(abort_req), .idle_len(idle_len), .txd(txd1), .tx_busy(busy1),
    .tx_done(done1), .tx_aborted(ab1), .buf_level(lvl1));

  int n_chk = 0, n_bad = 0;
  bit logging = 1'b0;
  int li = 0;
  bit lg0 [LOGN], lg1 [LOGN], dg0 [LOGN], dg1 [LOGN];
  bit ex [LOGN];
  int exn, ex_ones;
  logic [7:0] pay [64];

  always @(negedge clk)
    if (logging && li < LOGN) begin
      lg0[li] = txd0; lg1[li] = txd1; dg0[li] = done0; dg1[li] = done1;
      li++;
    end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void put_bit(input bit b, input bit stuffed);
    ex[exn] = b; exn++;
    if (stuffed) begin
      ex_ones = b ? ex_ones + 1 : 0;
      if (ex_ones == 5) begin ex[exn] = 1'b0; exn++; ex_ones = 0; end
    end
  endfunction

  function automatic void build(input int n, input bit w32);
    logic [31:0] crc, poly, fcs;
    int fw;
    fw = w32 ? 32 : 16;
    crc  = w32 ? 32'hFFFFFFFF : 32'h0000FFFF;
    poly = w32 ? 32'hEDB88320 : 32'h00008408;
    exn = 0; ex_ones = 0;
    for (int i = 0; i < 8; i++) put_bit(1'((8'h7E >> i) & 8'h1), 1'b0);
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        bit b, f;
        b = pay[k][i];
        f = crc[0] ^ b;
        crc = (crc >> 1) ^ (f ? poly : 32'h0);
        put_bit(b, 1'b1);
      end
    fcs = ~crc;
    for (int i = 0; i < fw; i++) put_bit(fcs[i], 1'b1);
    for (int i = 0; i < 8; i++) put_bit(1'((8'h7E >> i) & 8'h1), 1'b0);
  endfunction

  task automatic check_stream(input bit w32, input int n, input int idle);
    int s, bad, d;
    string tag;
    tag = w32 ? "R5 R3 R4 (32-bit)" : "R3 R4 R5 (16-bit)";
    build(n, w32);
    s = -1;
    for (int i = 0; i < LOGN; i++)
      if (s < 0 && (w32 ? lg1[i] : lg0[i]) == 1'b0) s = i;
    chk(s >= 0, tag, s, 0);
    if (s < 0) return;
    bad = -1;
    for (int i = 0; i < exn; i++)
      if (bad < 0 && (w32 ? lg1[s+i] : lg0[s+i]) != ex[i]) bad = i;
    chk(bad < 0, tag, bad, -1);
    for (int k = 0; k < idle + 2; k++)
      if ((w32 ? lg1[s+exn+k] : lg0[s+exn+k]) != 1'b1) begin
        chk(1'b0, "R7 idle ones", k, 1); break;
      end
    d = s + exn - 1 + idle;
    chk((w32 ? dg1[d] : dg0[d]) == 1'b1 && (w32 ? dg1[d-1] : dg0[d-1]) == 1'b0,
        "R7 done timing", d, d);
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_enable();
    @(negedge clk); tx_enable = 1'b1;
    @(negedge clk); tx_enable = 1'b0;
  endtask

  task automatic wait_done();
    int g;
    g = 0;
    while (!(done0 && done1) && g < 5000) begin @(negedge clk); g++; end
    chk(g < 5000, "R7 completion", g, 0);
    repeat (idle_len + 4) @(negedge clk);
  endtask

  task automatic run_frame(input int n, input int idle, input bit prefilled, input bit meddle);
    @(negedge clk); logging = 1'b0; li = 0;
    if (!prefilled) for (int i = 0; i < n; i++) write_byte(pay[i]);
    chk(int'(lvl0) == n, "R2 level after writes", lvl0, n);
    idle_len = IW'(idle);
    logging = 1'b1;
    pulse_enable();
    chk(busy0 && !done0 && !ab0, "R9 start clears status", {busy0, done0, ab0}, 3'b100);
    if (meddle) begin
      write_byte(8'hA5); write_byte(8'h3C);
      pulse_enable();
    end
    wait_done();
    logging = 1'b0;
    check_stream(1'b0, n, idle);
    check_stream(1'b1, n, idle);
    chk(lvl0 == 0 && lvl1 == 0, "R6 buffer empty after frame", lvl0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd0 && !busy0 && !done0 && !ab0 && lvl0 == 0, "R1 reset state",
        {txd0, busy0, done0, ab0}, 4'b1000);

    for (int i = 0; i < 4; i++) pay[i] = 8'hFF;
    run_frame(4, 0, 1'b0, 1'b0);
    pay[0] = 8'h00;
    run_frame(1, 1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) pay[i] = 8'h7E;
    run_frame(3, 5, 1'b0, 1'b1);
    pay[0] = 8'h1F; pay[1] = 8'hF8;
    run_frame(2, 2, 1'b0, 1'b1);

    for (int i = 0; i < DEPTH + 3; i++) begin
      if (i < DEPTH) pay[i] = 8'($urandom);
      write_byte(i < DEPTH ? pay[i] : 8'hEE);
    end
    chk(int'(lvl0) == DEPTH, "R2 full drops writes", lvl0, DEPTH);
    run_frame(DEPTH, 3, 1'b1, 1'b0);

    pulse_enable();
    repeat (20) @(negedge clk);
    chk(!busy0 && txd0 && done0, "R6 enable on empty buffer", {busy0, txd0}, 2'b01);

    for (int i = 0; i < 12; i++) write_byte(8'h00);
    @(negedge clk); logging = 1'b0; li = 0;
    idle_len = 8'd3; logging = 1'b1;
    pulse_enable();
    repeat (40) @(negedge clk);
    abort_req = 1'b1;
    @(negedge clk); abort_req = 1'b0;
    wait_done();
    logging = 1'b0;
    begin
      int s, p;
      bit ok;
      s = -1; p = -1;
      for (int i = 0; i < LOGN; i++) if (s < 0 && lg0[i] == 1'b0) s = i;
      for (int i = s + 8; i < LOGN; i++) if (s >= 0 && p < 0 && lg0[i] == 1'b1) p = i;
      ok = p > 0;
      if (ok) for (int k = 0; k < 8; k++) if (lg0[p+k] != 1'b1) ok = 1'b0;
      chk(ok, "R8 abort run of ones", p, s + 8);
      chk(ok && dg0[p+7+3] && !dg0[p+6+3], "R8 done after abort gap", p, p);
      chk(ab0 && ab1 && lvl0 == 0 && lvl1 == 0, "R8 abort flushes", {ab0, lvl0}, 1);
    end

    pay[0] = 8'h55; pay[1] = 8'hFF;
    run_frame(2, 4, 1'b0, 1'b0);
    chk(!ab0 && !ab1, "R9 aborted cleared", ab0, 0);

    for (int f = 0; f < 16; f++) begin
      int n;
      n = 1 + int'($urandom % DEPTH);
      for (int i = 0; i < n; i++) pay[i] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      run_frame(n, int'($urandom % 12), 1'b0, f[0]);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule